// File: doc/BRIEF.md
# Multi-Vector Accumulator Group Sequencer

This block steps one multi-vector multiply-accumulate operation through a two-dimensional accumulator array made of `VL_BITS/8` rows, each one vector wide. A start pulse carries a short descriptor and the 32-bit value of the selected base register. The descriptor gives the group size (two or four members), two source-group fields, a 2-bit base-register selector and a 3-bit row offset. For each group member the sequencer issues one read of a pair of source vector registers together with one accumulator row. It then waits for the element-wise datapath behind a one-bit handshake and writes the returned vector back over that same row.

Group members are spread across the array, not packed together. The stride is the row count divided by the group size. The first row is the base value plus the offset, reduced modulo the stride, and every later member adds one stride. In this way each member lands in its own half or quarter of the array. When the feature-enable input is low, a start is refused with a one-cycle undefined-instruction pulse and the array is never touched. The arithmetic on the 16-bit elements is done elsewhere. This block only orders the accesses.

Top module: `mvacc_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy_o`, `done_o`, `undef_o`, `vrd_en_o`, `acc_rd_en_o` and `acc_wr_en_o` are all low.
- R2: With `quad_i` = 0 an accepted operation performs exactly two read/write steps. With `quad_i` = 1 it performs exactly four.
- R3: At step r both source indices are the group base plus r. With `quad_i` = 0 the group base is the 4-bit field times 2. With `quad_i` = 1 it is the low 3 bits of the field times 4. The same rule applies to `src_a_fld_i` and `src_b_fld_i`.
- R4: The first accumulator row is (`base_val_i` + `off_i`) mod (ROWS / group size), with ROWS = VL_BITS/8. The 32-bit sum wraps on overflow.
- R5: Each later step uses the previous row plus ROWS / group size.
- R6: Each step asserts `vrd_en_o` and `acc_rd_en_o` together for one cycle. It writes back only in the cycle after `dp_valid_i` is sampled high while waiting. The write targets the row just read, and `acc_wdata_o` equals the sampled `dp_result_i`. A read and a write never occur in the same cycle.
- R7: `done_o` is high for exactly one cycle, the cycle directly after the last write. `busy_o` is low after it.
- R8: A start while `feat_en_i` is low gives a one-cycle `undef_o` pulse in the next cycle. It produces no read, no write and no busy.
- R9: A start that arrives while busy is ignored. The running operation keeps its own descriptor and step count.
- R10: `base_idx_o` is the selected base register index, binary 010 followed by `sel_i` (registers 8 to 11).
- R11: `dp_valid_i` outside the waiting phase causes no write and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| feat_en_i | input | 1 | Feature implemented; low rejects every start |
| start_i | input | 1 | Start pulse; descriptor and base value are sampled with it |
| quad_i | input | 1 | Group size: 0 = two members, 1 = four members |
| src_a_fld_i | input | 4 | First source group field |
| src_b_fld_i | input | 4 | Second source group field |
| sel_i | input | 2 | Base register selector |
| off_i | input | 3 | Row offset, 0 to 7 |
| base_val_i | input | 32 | Value of the selected base register |
| base_idx_o | output | 5 | Index of the base register to read |
| vrd_en_o | output | 1 | Source vector read request |
| vrd_a_o | output | 5 | First source vector index |
| vrd_b_o | output | 5 | Second source vector index |
| acc_rd_en_o | output | 1 | Accumulator row read |
| acc_wr_en_o | output | 1 | Accumulator row write |
| acc_row_o | output | $clog2(VL_BITS/8) | Accumulator row for the read or the write |
| acc_wdata_o | output | VL_BITS | Write-back data |
| dp_valid_i | input | 1 | Datapath result valid |
| dp_result_i | input | VL_BITS | Datapath result vector |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | One-cycle undefined-instruction pulse |

## Verification
The assertions check the local access rules on every cycle. Reads and writes are mutually exclusive. Every write goes to the row of the preceding read and follows a sampled result-valid. Completion is a single pulse right behind a write, a refused start never touches the array, and an idle sequencer issues no access. What the assertions cannot see is whether the row arithmetic is right, including the 32-bit wrap and the choice of stride per group size. The same holds for the source-index scaling in both forms, the exact number of steps, and the fact that a start arriving mid-operation leaves the running operation unchanged. Only the directed scenarios, which compare against expected rows and indices, can show those.

// File: rtl/mvacc_pkg.sv
package mvacc_pkg;

  localparam int unsigned FLD_W     = 4;
  localparam int unsigned OFF_W     = 3;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned XREG_W    = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned STEP_W    = 2;

  // Base registers sit at indices 8..11: fixed upper bits, selector below.
  localparam logic [REG_IDX_W-SEL_W-1:0] SEL_PREFIX = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_WRITE,
    ST_FIN
  } seq_state_e;

  // Captured per-operation context.
  typedef struct packed {
    logic [STEP_W-1:0]    last;
    logic [REG_IDX_W-1:0] a_base;
    logic [REG_IDX_W-1:0] b_base;
  } op_ctx_t;

  // Group base register index: pairs are aligned to 2, quads to 4.
  function automatic logic [REG_IDX_W-1:0] grp_base(input logic quad,
                                                    input logic [FLD_W-1:0] fld);
    if (quad) grp_base = {fld[FLD_W-2:0], 2'b00};
    else      grp_base = {fld, 1'b0};
  endfunction

endpackage

// File: rtl/mvacc_rst_sync.sv
module mvacc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;

  // Assert at once, release after STAGES clock edges (STAGES >= 2).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/mvacc_rowgen.sv
module mvacc_rowgen #(
  parameter int unsigned ROWS = 32,
  localparam int unsigned RW  = $clog2(ROWS)
) (
  input  logic          quad_i,
  input  logic [31:0]   base_val_i,
  input  logic [2:0]    off_i,
  output logic [RW-1:0] stride_o,
  output logic [RW-1:0] first_row_o
);

  localparam logic [RW-1:0] STRIDE_PAIR = RW'(ROWS / 2);
  localparam logic [RW-1:0] STRIDE_QUAD = RW'(ROWS / 4);

  logic [RW-1:0] mask;

  always_comb begin
    stride_o = quad_i ? STRIDE_QUAD : STRIDE_PAIR;
    mask     = stride_o - RW'(1);
    // Stride is a power of two: modulo keeps the low bits of the wrapped sum.
    first_row_o = RW'((base_val_i + 32'(off_i)) & 32'(mask));
  end

endmodule

// File: rtl/mvacc_ctrl.sv
module mvacc_ctrl
  import mvacc_pkg::*;
#(
  parameter int unsigned DW = 256,
  parameter int unsigned RW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 feat_en_i,
  input  logic                 start_i,
  input  op_ctx_t              ctx_i,
  input  logic [RW-1:0]        stride_i,
  input  logic [RW-1:0]        first_row_i,
  input  logic                 dp_valid_i,
  input  logic [DW-1:0]        dp_result_i,
  output logic                 vrd_en_o,
  output logic [REG_IDX_W-1:0] vrd_a_o,
  output logic [REG_IDX_W-1:0] vrd_b_o,
  output logic                 acc_rd_en_o,
  output logic                 acc_wr_en_o,
  output logic [RW-1:0]        acc_row_o,
  output logic [DW-1:0]        acc_wdata_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 undef_o
);

  seq_state_e          state_q, state_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic [RW-1:0]       row_q, row_d;
  logic [RW-1:0]       stride_q;
  op_ctx_t             ctx_q;
  logic                undef_q, undef_d;
  logic                cap_en;
  logic                res_en;
  logic [DW-1:0]       res_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    row_d   = row_q;
    undef_d = 1'b0;
    cap_en  = 1'b0;
    res_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (feat_en_i) begin
            state_d = ST_ISSUE;
            cap_en  = 1'b1;
            step_d  = '0;
            row_d   = first_row_i;
          end else begin
            undef_d = 1'b1;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (dp_valid_i) begin
          res_en  = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (step_q == ctx_q.last) begin
          state_d = ST_FIN;
        end else begin
          state_d = ST_ISSUE;
          step_d  = STEP_W'(step_q + STEP_W'(1));
          row_d   = RW'(row_q + stride_q);
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      row_q    <= '0;
      undef_q  <= 1'b0;
      stride_q <= '0;
      ctx_q    <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      row_q   <= row_d;
      undef_q <= undef_d;
      if (cap_en) begin
        stride_q <= stride_i;
        ctx_q    <= ctx_i;
      end
    end
  end

  // Result holding register: datapath only, no reset.
  always_ff @(posedge clk) begin
    if (res_en) res_q <= dp_result_i;
  end

  // Moore outputs
  always_comb begin
    vrd_en_o    = (state_q == ST_ISSUE);
    acc_rd_en_o = (state_q == ST_ISSUE);
    acc_wr_en_o = (state_q == ST_WRITE);
    done_o      = (state_q == ST_FIN);
    busy_o      = (state_q != ST_IDLE);
    undef_o     = undef_q;
    vrd_a_o     = REG_IDX_W'(ctx_q.a_base + REG_IDX_W'(step_q));
    vrd_b_o     = REG_IDX_W'(ctx_q.b_base + REG_IDX_W'(step_q));
    acc_row_o   = row_q;
    acc_wdata_o = res_q;
  end

endmodule

// File: rtl/mvacc_seq.sv
module mvacc_seq
  import mvacc_pkg::*;
#(
  parameter int unsigned VL_BITS = 256,
  localparam int unsigned ROWS   = VL_BITS / 8,
  localparam int unsigned RW     = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 feat_en_i,
  input  logic                 start_i,
  input  logic                 quad_i,
  input  logic [FLD_W-1:0]     src_a_fld_i,
  input  logic [FLD_W-1:0]     src_b_fld_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [XREG_W-1:0]    base_val_i,
  output logic [REG_IDX_W-1:0] base_idx_o,
  output logic                 vrd_en_o,
  output logic [REG_IDX_W-1:0] vrd_a_o,
  output logic [REG_IDX_W-1:0] vrd_b_o,
  output logic                 acc_rd_en_o,
  output logic                 acc_wr_en_o,
  output logic [RW-1:0]        acc_row_o,
  output logic [VL_BITS-1:0]   acc_wdata_o,
  input  logic                 dp_valid_i,
  input  logic [VL_BITS-1:0]   dp_result_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 undef_o
);

  logic          rst_n_int;
  logic [RW-1:0] stride;
  logic [RW-1:0] first_row;
  op_ctx_t       ctx;

  assign base_idx_o = {SEL_PREFIX, sel_i};

  always_comb begin
    ctx.last   = quad_i ? STEP_W'(3) : STEP_W'(1);
    ctx.a_base = grp_base(quad_i, src_a_fld_i);
    ctx.b_base = grp_base(quad_i, src_b_fld_i);
  end

  mvacc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mvacc_rowgen #(.ROWS(ROWS)) u_rowgen (
    .quad_i      (quad_i),
    .base_val_i  (base_val_i),
    .off_i       (off_i),
    .stride_o    (stride),
    .first_row_o (first_row)
  );

  mvacc_ctrl #(.DW(VL_BITS), .RW(RW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .feat_en_i   (feat_en_i),
    .start_i     (start_i),
    .ctx_i       (ctx),
    .stride_i    (stride),
    .first_row_i (first_row),
    .dp_valid_i  (dp_valid_i),
    .dp_result_i (dp_result_i),
    .vrd_en_o    (vrd_en_o),
    .vrd_a_o     (vrd_a_o),
    .vrd_b_o     (vrd_b_o),
    .acc_rd_en_o (acc_rd_en_o),
    .acc_wr_en_o (acc_wr_en_o),
    .acc_row_o   (acc_row_o),
    .acc_wdata_o (acc_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .undef_o     (undef_o)
  );

endmodule

// File: rtl/mvacc_seq_chk.sv
module mvacc_seq_chk #(
  parameter int unsigned VL_BITS = 256,
  localparam int unsigned RW     = $clog2(VL_BITS / 8)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vrd_en_o,
  input logic          acc_rd_en_o,
  input logic          acc_wr_en_o,
  input logic [RW-1:0] acc_row_o,
  input logic          dp_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          undef_o
);

  logic [RW-1:0] rd_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_row_q <= '0;
    else if (acc_rd_en_o) rd_row_q <= acc_row_o;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd_en_o && acc_wr_en_o));  // R6
  AST_WR_SAME_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_en_o |-> (acc_row_o == rd_row_q));  // R6
  AST_WR_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_en_o |-> $past(dp_valid_i));  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(acc_wr_en_o));  // R7
  AST_UNDEF_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (!busy_o && !vrd_en_o && !acc_rd_en_o && !acc_wr_en_o));  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!vrd_en_o && !acc_rd_en_o && !acc_wr_en_o && !done_o));  // R1

endmodule

bind mvacc_seq mvacc_seq_chk #(.VL_BITS(VL_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vrd_en_o    (vrd_en_o),
  .acc_rd_en_o (acc_rd_en_o),
  .acc_wr_en_o (acc_wr_en_o),
  .acc_row_o   (acc_row_o),
  .dp_valid_i  (dp_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .undef_o     (undef_o)
);

// File: tb/mvacc_seq_bench.sv
`timescale 1ns/1ps
module mvacc_seq_bench;

  localparam int unsigned VL   = 256;
  localparam int unsigned ROWS = VL / 8;
  localparam int unsigned RW   = $clog2(ROWS);

  logic          clk;
  logic          rst_n;
  logic          feat_en_i;
  logic          start_i;
  logic          quad_i;
  logic [3:0]    src_a_fld_i;
  logic [3:0]    src_b_fld_i;
  logic [1:0]    sel_i;
  logic [2:0]    off_i;
  logic [31:0]   base_val_i;
  logic [4:0]    base_idx_o;
  logic          vrd_en_o;
  logic [4:0]    vrd_a_o;
  logic [4:0]    vrd_b_o;
  logic          acc_rd_en_o;
  logic          acc_wr_en_o;
  logic [RW-1:0] acc_row_o;
  logic [VL-1:0] acc_wdata_o;
  logic          dp_valid_i;
  logic [VL-1:0] dp_result_i;
  logic          busy_o;
  logic          done_o;
  logic          undef_o;

  int total = 0;
  int bad   = 0;

  mvacc_seq #(.VL_BITS(VL)) u_mvacc_seq (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input bit ok, input string detail);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  function automatic logic [VL-1:0] pattern(input int tag, input int r);
    logic [31:0] w;
    w = 32'hA500_0000 ^ 32'(tag << 8) ^ 32'(r);
    return {(VL/32){w}};
  endfunction

  task automatic quiet_check(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, !vrd_en_o && !acc_rd_en_o && !acc_wr_en_o && !busy_o,
          $sformatf("activity act vrd=%0b rd=%0b wr=%0b busy=%0b exp all 0",
                    vrd_en_o, acc_rd_en_o, acc_wr_en_o, busy_o));
    end
  endtask

  // Run one operation and check every step against the requirement model.
  task automatic run_op(input int tag, input logic q, input logic [3:0] fa,
                        input logic [3:0] fb, input logic [31:0] bv,
                        input logic [2:0] of, input int dly, input bit poke);
    int unsigned cnt, stride, first;
    logic [31:0] s;
    logic [4:0]  a0, b0;
    int r = 0, pend = 0, last_wr = -10, issued = 0;
    bit fin = 0, drove = 0, drove_prev = 0, clr_start = 0;
    cnt    = q ? 4 : 2;
    stride = ROWS / cnt;
    s      = bv + 32'(of);
    first  = s % stride;
    a0     = q ? {fa[2:0], 2'b00} : {fa, 1'b0};
    b0     = q ? {fb[2:0], 2'b00} : {fb, 1'b0};
    @(negedge clk);
    quad_i = q; src_a_fld_i = fa; src_b_fld_i = fb;
    base_val_i = bv; off_i = of; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      drove_prev = drove;
      drove = 0;
      if (dp_valid_i) dp_valid_i = 1'b0;
      if (clr_start) begin
        start_i = 1'b0; clr_start = 0;
        quad_i = q; src_a_fld_i = fa; src_b_fld_i = fb; base_val_i = bv; off_i = of;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          dp_valid_i = 1'b1; dp_result_i = pattern(tag, r); drove = 1;
        end
      end
      if (vrd_en_o) begin
        issued++;
        chk("R3", vrd_a_o == 5'(a0 + 5'(r)),
            $sformatf("src a act=%0d exp=%0d", vrd_a_o, a0 + 5'(r)));
        chk("R3", vrd_b_o == 5'(b0 + 5'(r)),
            $sformatf("src b act=%0d exp=%0d", vrd_b_o, b0 + 5'(r)));
        chk("R6", acc_rd_en_o && !acc_wr_en_o,
            $sformatf("read pair act rd=%0b wr=%0b exp 1 0", acc_rd_en_o, acc_wr_en_o));
        chk(r == 0 ? "R4" : "R5", acc_row_o == RW'(first + r * stride),
            $sformatf("read row act=%0d exp=%0d", acc_row_o, first + r * stride));
        pend = dly;
        if (poke && r == 0) begin
          start_i = 1'b1; quad_i = ~q; src_a_fld_i = ~fa; src_b_fld_i = ~fb;
          base_val_i = ~bv; off_i = ~of; clr_start = 1;
        end
      end
      if (acc_wr_en_o) begin
        chk("R6", drove_prev, "write act=without prior valid exp=after valid");
        chk("R6", acc_row_o == RW'(first + r * stride),
            $sformatf("write row act=%0d exp=%0d", acc_row_o, first + r * stride));
        chk("R6", acc_wdata_o == pattern(tag, r),
            $sformatf("wdata act=%h exp=%h", acc_wdata_o, pattern(tag, r)));
        last_wr = cyc;
        r++;
      end
      if (done_o) begin
        chk("R7", cyc == last_wr + 1,
            $sformatf("done cycle act=%0d exp=%0d", cyc, last_wr + 1));
        chk("R2", r == int'(cnt) && issued == int'(cnt),
            $sformatf("steps act=%0d/%0d exp=%0d", r, issued, cnt));
        chk("R9", !poke || r == int'(cnt),
            $sformatf("busy start changed steps act=%0d exp=%0d", r, cnt));
        fin = 1;
      end
      @(negedge clk);
    end
    chk("R7", fin, $sformatf("done act=never exp=after step %0d", cnt));
    chk("R7", !done_o && !busy_o,
        $sformatf("after done act done=%0b busy=%0b exp 0 0", done_o, busy_o));
  endtask

  task automatic t_reset();
    chk("R1", !busy_o && !done_o && !undef_o && !vrd_en_o && !acc_rd_en_o && !acc_wr_en_o,
        $sformatf("reset outputs act busy=%0b done=%0b undef=%0b exp 0",
                  busy_o, done_o, undef_o));
    for (int k = 0; k < 4; k++) begin
      sel_i = 2'(k);
      #1;
      chk("R10", base_idx_o == 5'(8 + k),
          $sformatf("base idx act=%0d exp=%0d", base_idx_o, 8 + k));
    end
  endtask

  task automatic t_undef();
    @(negedge clk);
    feat_en_i = 1'b0; quad_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8", undef_o && !busy_o,
        $sformatf("undef act=%0b busy=%0b exp 1 0", undef_o, busy_o));
    @(negedge clk);
    chk("R8", !undef_o, $sformatf("undef width act=%0b exp 0", undef_o));
    quiet_check("R8", 5);
    feat_en_i = 1'b1;
  endtask

  task automatic t_stray_valid();
    @(negedge clk);
    dp_valid_i = 1'b1; dp_result_i = pattern(99, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11", !acc_wr_en_o && !busy_o,
          $sformatf("stray valid act wr=%0b busy=%0b exp 0 0", acc_wr_en_o, busy_o));
    end
    dp_valid_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; feat_en_i = 1'b1; start_i = 1'b0; quad_i = 1'b0;
    src_a_fld_i = '0; src_b_fld_i = '0; sel_i = '0; off_i = '0;
    base_val_i = '0; dp_valid_i = 1'b0; dp_result_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // pair form: (37+5) mod 16 = 10, rows 10 and 26
    run_op(1, 1'b0, 4'b1011, 4'b0101, 32'd37, 3'd5, 1, 0);
    // quad form with 32-bit wrap: (FFFFFFFE+7) = 5, mod 8 = 5
    run_op(2, 1'b1, 4'b1101, 4'b0110, 32'hFFFF_FFFE, 3'd7, 3, 0);
    // pair form with large offset: (0x1F+7) mod 16 = 6
    run_op(3, 1'b0, 4'b1111, 4'b0000, 32'h0000_001F, 3'd7, 2, 0);
    // start pulsed while busy must not disturb the run
    run_op(4, 1'b1, 4'b0011, 4'b1000, 32'd2, 3'd1, 4, 1);
    quiet_check("R9", 4);
    t_undef();
    t_stray_valid();
    run_op(5, 1'b0, 4'b0001, 4'b0010, 32'd0, 3'd0, 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule